// File: doc/BRIEF.md
# APB Transfer Manager

This block turns a plain request interface into APB transfers, one at a time. A requester presents a valid flag, a direction bit, an address and write data. When the block accepts the request it copies those values into holding registers. It then runs a SETUP cycle followed by one or more ACCESS cycles against a single subordinate.

The transfer finishes only on a clock edge where select, enable and the subordinate's ready are all high. On that edge the block samples the read data and the error flag. One cycle later it returns them to the requester together with a single-cycle done pulse.

The block holds one transfer in flight at most. The request-side ready output tells the requester when the next request can be taken. If a request is waiting at the completion edge, the block goes straight from ACCESS into the next SETUP and does not pass through an idle cycle.

Top module: `apb_xfer_master`

## Requirements
- R1: While `rst_n` is low, `bus_sel`, `bus_enable` and `done` are low and `req_ready` is high.
- R2: A request with `req_valid` high in the idle state is taken on that edge. In the next cycle `bus_sel` is 1 and `bus_enable` is 0, and `bus_addr`, `bus_write` and `bus_wdata` equal the values the request carried.
- R3: A SETUP cycle (`bus_sel`=1, `bus_enable`=0) is always followed by an ACCESS cycle (`bus_sel`=1, `bus_enable`=1). This holds whatever `bus_ready` shows during SETUP, so a transfer lasts at least two clocks.
- R4: While in ACCESS with `bus_ready` low, the block stays in ACCESS and every bus output keeps its value.
- R5: A transfer completes only when `bus_sel`, `bus_enable` and `bus_ready` are all high on the same edge. `bus_ready` seen while idle or in SETUP has no effect.
- R6: `bus_addr`, `bus_write` and `bus_wdata` stay constant from SETUP through the completion edge, even when the request inputs change.
- R7: `done` is high for exactly the one cycle after a completion edge. In that cycle `rd_data` and `rd_err` equal the `bus_rdata` and `bus_err` sampled on the completion edge.
- R8: After completion with `req_valid` low, the block returns to idle with `bus_sel` and `bus_enable` low.
- R9: After completion with `req_valid` high, the block moves directly to SETUP for the new request: `bus_sel` stays high, `bus_enable` is low, and the new request's fields are presented.
- R10: `req_ready` is high in the idle state and in an ACCESS cycle where `bus_ready` is high, and low at all other times. No request is taken while a transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Requester has a transfer to issue |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Request is taken when high together with req_valid |
| done | output | 1 | One-cycle pulse after a transfer completes |
| rd_data | output | DATA_W | Read data of the completed transfer |
| rd_err | output | 1 | Error flag of the completed transfer |
| bus_sel | output | 1 | APB select |
| bus_enable | output | 1 | APB enable (ACCESS phase marker) |
| bus_write | output | 1 | APB direction |
| bus_addr | output | ADDR_W | APB address |
| bus_wdata | output | DATA_W | APB write data |
| bus_rdata | input | DATA_W | APB read data from the subordinate |
| bus_ready | input | 1 | APB ready from the subordinate |
| bus_err | input | 1 | APB error response from the subordinate |

## Verification
The hardest situation to reach is a completion edge that coincides with a waiting request. That edge must finish one transfer, emit done and start the next SETUP without dropping select. The stimulus holds `req_valid` high through long wait-state stretches, and it also changes the request fields during those stretches. This hits the direct SETUP path and confirms that the presented fields ignore the changes. A long random phase then mixes `bus_ready` toggling in every phase with random request traffic, and the reference model is compared on every clock.

// File: rtl/apb_xfer_master.sv
module apb_xfer_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err,
  output logic              bus_sel,
  output logic              bus_enable,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_err
);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS} phase_t;

  phase_t ph, ph_n;
  logic   finish_x;
  logic   take;

  assign bus_sel    = (ph != PH_IDLE);
  assign bus_enable = (ph == PH_ACCESS);
  assign finish_x   = bus_sel & bus_enable & bus_ready;
  assign req_ready  = (ph == PH_IDLE) | finish_x;
  assign take       = req_valid & req_ready;

  always_comb begin
    ph_n = ph;
    unique case (ph)
      PH_IDLE:   if (take) ph_n = PH_SETUP;
      PH_SETUP:  ph_n = PH_ACCESS;
      PH_ACCESS: if (finish_x) ph_n = take ? PH_SETUP : PH_IDLE;
      default:   ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
      rd_err    <= 1'b0;
    end else begin
      ph   <= ph_n;
      done <= finish_x;
      if (take) begin
        bus_write <= req_write;
        bus_addr  <= req_addr;
        bus_wdata <= req_wdata;
      end
      if (finish_x) begin
        rd_data <= bus_rdata;
        rd_err  <= bus_err;
      end
    end
  end

endmodule

module apb_xfer_master_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_err,
  input logic              bus_sel,
  input logic              bus_enable,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_ready,
  input logic              bus_err
);

  AST_SETUP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_enable) |=> (bus_sel && bus_enable)); // R3

  AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_enable |-> bus_sel); // R3

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_enable && !bus_ready) |=>
      (bus_sel && bus_enable && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))); // R4

  AST_SETUP_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_enable) |=> ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata))); // R6

  AST_DONE_FOLLOWS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_enable && bus_ready) |=> done); // R7

  AST_DONE_NEEDS_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_sel && bus_enable && bus_ready)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_enable && bus_ready) |=>
      (rd_data == $past(bus_rdata) && rd_err == $past(bus_err))); // R7

  AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !(bus_enable && bus_ready)) |-> !req_ready); // R10

endmodule

bind apb_xfer_master apb_xfer_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/apb_xfer_master_tb.sv
module apb_xfer_master_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, done, rd_err;
  logic [DATA_W-1:0] rd_data;
  logic              bus_sel, bus_enable, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              bus_ready = 1'b0, bus_err = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int                ph = 0;
  logic              m_wr = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [DATA_W-1:0] m_wd = '0;
  logic              m_done = 1'b0;
  logic [DATA_W-1:0] m_rd = '0;
  logic              m_err = 1'b0;
  string             m_tag = "R1";

  always #5 clk = ~clk;

  apb_xfer_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rd_data(rd_data), .rd_err(rd_err),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic r,
                      input logic [DATA_W-1:0] rd, input logic e);
    logic exp_rdy;
    logic fin;
    string ftag;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    bus_ready = r; bus_rdata = rd; bus_err = e;
    #1;
    chk(64'(bus_sel), 64'(ph != 0), m_tag, "bus_sel");
    chk(64'(bus_enable), 64'(ph == 2), m_tag, "bus_enable");
    if (ph != 0) begin
      ftag = (m_tag == "R2" || m_tag == "R9") ? m_tag : "R6";
      chk(64'(bus_addr), 64'(m_addr), ftag, "bus_addr");
      chk(64'(bus_write), 64'(m_wr), ftag, "bus_write");
      chk(64'(bus_wdata), 64'(m_wd), ftag, "bus_wdata");
    end
    exp_rdy = (ph == 0) || (ph == 2 && r);
    chk(64'(req_ready), 64'(exp_rdy), "R10", "req_ready");
    chk(64'(done), 64'(m_done), "R7", "done");
    if (m_done) begin
      chk(64'(rd_data), 64'(m_rd), "R7", "rd_data");
      chk(64'(rd_err), 64'(m_err), "R7", "rd_err");
    end
    fin = (ph == 2) && r;
    m_done = fin;
    if (fin) begin m_rd = rd; m_err = e; end
    if (v && exp_rdy) begin
      m_tag = (ph == 0) ? "R2" : "R9";
      m_addr = a; m_wr = w; m_wd = d; ph = 1;
    end else if (ph == 1) begin
      m_tag = "R3"; ph = 2;
    end else if (ph == 2 && !r) begin
      m_tag = "R4";
    end else if (fin) begin
      m_tag = "R8"; ph = 0;
    end else begin
      m_tag = "R5";
    end
    @(negedge clk);
    cycles++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    bus_ready = 1'b1;
    #1;
    chk(64'(bus_sel), 64'(0), "R1", "bus_sel in reset");
    chk(64'(bus_enable), 64'(0), "R1", "bus_enable in reset");
    chk(64'(done), 64'(0), "R1", "done in reset");
    chk(64'(req_ready), 64'(1), "R1", "req_ready in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: ready while idle does nothing
    repeat (3) step(1'b0, 1'b0, 16'h0, 32'h0, 1'b1, 32'h0, 1'b0);
    // R2 R3: zero-wait write
    step(1'b1, 1'b1, 16'h1234, 32'hCAFE_0001, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b0, 16'hFFFF, 32'h0, 1'b1, 32'h0, 1'b0);
    step(1'b0, 1'b0, 16'hFFFF, 32'h0, 1'b1, 32'h5555_AAAA, 1'b0);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    // R4 R6 R10: read with waits, request inputs changing, valid held
    step(1'b1, 1'b0, 16'h00A0, 32'h0, 1'b0, 32'h0, 1'b0);
    for (int i = 0; i < 4; i++)
      step(1'b1, 1'b1, 16'(16'h0BB0 + i), 32'(i), 1'b0, 32'hDEAD_0000, 1'b1);
    // R9: completion with a request waiting
    step(1'b1, 1'b1, 16'h0C00, 32'h7777_8888, 1'b1, 32'h1357_9BDF, 1'b1);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b1, 32'h0246_8ACE, 1'b0);
    // R8: back to idle
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 32'h0, 1'b0);

    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 16'($urandom),
           32'($urandom), 1'($urandom_range(0, 2) != 0), 32'($urandom),
           1'($urandom_range(0, 3) == 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule